// File: doc/BRIEF.md
# Key-Protected 64-bit Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus with write and read strobes, a word address and a data word. A 64-bit up-counter advances on a tick input and is compared against a 64-bit period. Both the counter and the period are reachable as a low and a high 32-bit word. Three more words hold the timer control, the global control and the watchdog control.

Software first sets up the period and the counting mode. It then arms the watchdog by writing two 16-bit keys, in order, into the upper half of the watchdog control word. From the first key onward every configuration word is frozen. While armed, software has to keep repeating the two-key sequence; each completed sequence restarts the count from zero. If the count ever reaches the period while the watchdog is armed, the block raises a reset request that stays high until system reset, and it sets a timeout flag.

Top module: `wdk_timer`

## Requirements
- R1: After synchronous reset every readable word returns zero, `rst_req` is low and the watchdog is unarmed (configuration writes are accepted).
- R2: Word addresses are: 4 counter low, 5 counter high, 6 period low, 7 period high, 8 timer control, 9 global control, 10 watchdog control. `rd_data` is registered and shows the addressed word one cycle after `rd_en`. Any other address reads zero. The watchdog control word reads as timeout flag at bit 15, enable at bit 14 and zero elsewhere (the key field reads zero). The counter words return the live count.
- R3: The counter advances by one on each clock cycle with `tick` high, and only when all of these hold: global control bit 0 and bit 1 are both 1, global control bits 3:2 equal 2 (64-bit watchdog mode), and timer control bits 7:6 are nonzero.
- R4: While global control bit 0 is 0, the low counter word is held at zero and writes to it have no effect. Global control bit 1 does the same for the high word.
- R5: A counting tick that finds the count equal to the period is an expiry. In continuous mode (timer control bits 7:6 = 2 or 3) the count returns to zero. In one-shot mode (bits 7:6 = 1) the count stays at the period.
- R6: When enable (bit 14, either already stored or set in the same write) is on, writing key 0xA5C6 in bits 31:16 of the watchdog control word moves the watchdog from unarmed to pre-armed. A following write of key 0xDA7E moves it to armed and clears the count to zero.
- R7: While armed, key 0xA5C6 enters a service state. A following key 0xDA7E returns the watchdog to armed and clears the count to zero.
- R8: A watchdog control write whose key is any other value, or is a valid key out of order, leaves the watchdog state unchanged and does not clear the count.
- R9: From pre-armed onward, writes to the counter, period, timer control and global control words, and to the enable bit, are ignored.
- R10: An expiry while armed or in service sets the timeout flag and drives `rst_req` high in the following cycle. `rst_req` then stays high until system reset. An expiry while unarmed or pre-armed does neither.
- R11: Writing 1 to watchdog control bit 15 clears the timeout flag in any state. Once set, enable cannot be cleared by any write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable pulse, one count per high cycle |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Registered read data |
| rst_req | output | 1 | Sticky reset request on watchdog timeout |

## Verification
The assertions watch on every cycle that the count either holds or steps by exactly one when no write or restart intervenes, that the watchdog never leaves the unarmed state except towards pre-armed, that an armed watchdog only moves to service, that the reset request and the enable bit never fall, and that a locked period word never changes under a write. Only the bench scenarios show the key sequences end to end: that a wrong or out-of-order key leaves the count alone, that repeated service keeps the reset request low, that the request rises on the exact tick where the count meets the period, and that the flag clears by a write of one to bit 15 while the request stays high.

// File: rtl/wdk_pkg.sv
`timescale 1ns/1ps
package wdk_pkg;

    // Word indices of the register map (byte offset divided by four)
    localparam int unsigned IDX_CNT_LO = 4;
    localparam int unsigned IDX_CNT_HI = 5;
    localparam int unsigned IDX_PRD_LO = 6;
    localparam int unsigned IDX_PRD_HI = 7;
    localparam int unsigned IDX_TCTL   = 8;
    localparam int unsigned IDX_GCTL   = 9;
    localparam int unsigned IDX_WCTL   = 10;

    // Field positions
    localparam int unsigned TCTL_MODE_LSB = 6;
    localparam int unsigned GCTL_LO_OUT   = 0;
    localparam int unsigned GCTL_HI_OUT   = 1;
    localparam int unsigned GCTL_TMR_LSB  = 2;
    localparam int unsigned WCTL_EN_BIT   = 14;
    localparam int unsigned WCTL_FLAG_BIT = 15;
    localparam int unsigned WCTL_KEY_LSB  = 16;

    localparam logic [15:0] KEY_OPEN  = 16'hA5C6;
    localparam logic [15:0] KEY_CLOSE = 16'hDA7E;
    localparam logic [1:0]  TMR_WDOG  = 2'd2;

    typedef enum logic [1:0] {
        EMODE_OFF  = 2'd0,
        EMODE_ONCE = 2'd1,
        EMODE_CONT = 2'd2,
        EMODE_ALT  = 2'd3
    } emode_e;

    typedef enum logic [1:0] {
        WD_IDLE    = 2'd0,
        WD_PRE     = 2'd1,
        WD_ARMED   = 2'd2,
        WD_SERVICE = 2'd3
    } wd_state_e;

    // Decoded view of the counting controls
    typedef struct packed {
        logic   lo_live;
        logic   hi_live;
        logic   run;
        logic   one_shot;
    } cnt_ctl_t;

    // Watchdog status bits visible in the control word
    typedef struct packed {
        logic flag;
        logic en;
    } wd_stat_t;

    function automatic cnt_ctl_t decode_ctl(input logic       lo_out,
                                            input logic       hi_out,
                                            input logic [1:0] tmr_mode,
                                            input logic [1:0] en_mode);
        cnt_ctl_t c;
        c.lo_live  = lo_out;
        c.hi_live  = hi_out;
        c.run      = lo_out && hi_out && (tmr_mode == TMR_WDOG)
                     && (emode_e'(en_mode) != EMODE_OFF);
        c.one_shot = (emode_e'(en_mode) == EMODE_ONCE);
        return c;
    endfunction

    function automatic logic is_locked(input wd_state_e s);
        return s != WD_IDLE;
    endfunction

endpackage

// File: rtl/wdk_cfg_regs.sv
`timescale 1ns/1ps
module wdk_cfg_regs
    import wdk_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            locked,
    input  logic            wr_prd_lo,
    input  logic            wr_prd_hi,
    input  logic            wr_tctl,
    input  logic            wr_gctl,
    input  logic [DW-1:0]   wr_data,
    output logic [2*DW-1:0] period,
    output logic [DW-1:0]   tctl,
    output logic [DW-1:0]   gctl
);

    logic [DW-1:0] prd_lo_q, prd_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prd_lo_q <= '0;
            prd_hi_q <= '0;
            tctl     <= '0;
            gctl     <= '0;
        end else if (!locked) begin
            if (wr_prd_lo) prd_lo_q <= wr_data;
            if (wr_prd_hi) prd_hi_q <= wr_data;
            if (wr_tctl)   tctl     <= wr_data;
            if (wr_gctl)   gctl     <= wr_data;
        end
    end

    assign period = {prd_hi_q, prd_lo_q};

    // Locked configuration words do not move under writes
    assert_period_locked_R9: assert property (@(posedge clk) disable iff (rst)
        locked && (wr_prd_lo || wr_prd_hi) |=> $stable(period));
    assert_ctl_locked_R9: assert property (@(posedge clk) disable iff (rst)
        locked && (wr_tctl || wr_gctl) |=> $stable(tctl) && $stable(gctl));

endmodule

// File: rtl/wdk_counter.sv
`timescale 1ns/1ps
module wdk_counter
    import wdk_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  cnt_ctl_t        ctl,
    input  logic            tick,
    input  logic            restart,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [DW-1:0]   wr_data,
    input  logic [2*DW-1:0] period,
    output logic [2*DW-1:0] count,
    output logic            expire
);

    localparam int CW = 2 * DW;

    logic [CW-1:0] count_nx;
    logic          step;

    assign step = tick && ctl.run;

    always_comb begin
        count_nx = count;
        expire   = 1'b0;
        if (step) begin
            if (count == period) begin
                expire   = 1'b1;
                count_nx = ctl.one_shot ? count : '0;
            end else begin
                count_nx = count + 1'b1;
            end
        end
        if (wr_lo)        count_nx[DW-1:0]  = wr_data;
        if (wr_hi)        count_nx[CW-1:DW] = wr_data;
        if (restart)      count_nx          = '0;
        if (!ctl.lo_live) count_nx[DW-1:0]  = '0;
        if (!ctl.hi_live) count_nx[CW-1:DW] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count_nx;
    end

    assert_step_by_one_R3: assert property (@(posedge clk) disable iff (rst)
        step && !restart && !wr_lo && !wr_hi && ctl.lo_live && ctl.hi_live
        && (count != period) |=> count == $past(count) + 1'b1);
    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !step && !restart && !wr_lo && !wr_hi && ctl.lo_live && ctl.hi_live
        |=> $stable(count));
    assert_low_half_reset_R4: assert property (@(posedge clk) disable iff (rst)
        !ctl.lo_live |=> count[DW-1:0] == '0);

endmodule

// File: rtl/wdk_key_fsm.sv
`timescale 1ns/1ps
module wdk_key_fsm
    import wdk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wctl_wr,
    input  logic [15:0] key,
    input  logic        en_bit,
    input  logic        flag_clr,
    input  logic        expire,
    output wd_state_e   state,
    output wd_stat_t    stat,
    output logic        restart,
    output logic        rst_req
);

    wd_state_e state_nx;
    logic      en_eff;
    logic      armed;

    assign en_eff = stat.en || en_bit;
    assign armed  = (state == WD_ARMED) || (state == WD_SERVICE);

    always_comb begin
        state_nx = state;
        restart  = 1'b0;
        if (wctl_wr) begin
            unique case (state)
                WD_IDLE:    if (en_eff && key == KEY_OPEN) state_nx = WD_PRE;
                WD_PRE:     if (key == KEY_CLOSE) begin
                                state_nx = WD_ARMED;
                                restart  = 1'b1;
                            end
                WD_ARMED:   if (key == KEY_OPEN) state_nx = WD_SERVICE;
                WD_SERVICE: if (key == KEY_CLOSE) begin
                                state_nx = WD_ARMED;
                                restart  = 1'b1;
                            end
                default:    state_nx = WD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= WD_IDLE;
            stat    <= '0;
            rst_req <= 1'b0;
        end else begin
            state <= state_nx;
            if (wctl_wr && state == WD_IDLE && en_bit) stat.en <= 1'b1;
            if (expire && armed)
                stat.flag <= 1'b1;
            else if (wctl_wr && flag_clr)
                stat.flag <= 1'b0;
            if (expire && armed) rst_req <= 1'b1;
        end
    end

    assert_idle_exit_R6: assert property (@(posedge clk) disable iff (rst)
        state == WD_IDLE |=> state == WD_IDLE || state == WD_PRE);
    assert_armed_exit_R7: assert property (@(posedge clk) disable iff (rst)
        state == WD_ARMED |=> state == WD_ARMED || state == WD_SERVICE);
    assert_no_disarm_R8: assert property (@(posedge clk) disable iff (rst)
        state != WD_IDLE |=> state != WD_IDLE);
    assert_req_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> rst_req);
    assert_enable_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        stat.en |=> stat.en);

endmodule

// File: rtl/wdk_timer.sv
`timescale 1ns/1ps
module wdk_timer
    import wdk_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    output logic              rst_req
);

    localparam int CW = 2 * DW;

    logic [CW-1:0] period, count;
    logic [DW-1:0] tctl, gctl, wctl_rd;
    logic          locked, expire, restart;
    wd_state_e     state;
    wd_stat_t      stat;
    cnt_ctl_t      ctl;

    logic sel_cnt_lo, sel_cnt_hi, sel_prd_lo, sel_prd_hi;
    logic sel_tctl, sel_gctl, sel_wctl;

    assign sel_cnt_lo = addr == ADDR_W'(IDX_CNT_LO);
    assign sel_cnt_hi = addr == ADDR_W'(IDX_CNT_HI);
    assign sel_prd_lo = addr == ADDR_W'(IDX_PRD_LO);
    assign sel_prd_hi = addr == ADDR_W'(IDX_PRD_HI);
    assign sel_tctl   = addr == ADDR_W'(IDX_TCTL);
    assign sel_gctl   = addr == ADDR_W'(IDX_GCTL);
    assign sel_wctl   = addr == ADDR_W'(IDX_WCTL);

    assign locked = is_locked(state);
    assign ctl    = decode_ctl(gctl[GCTL_LO_OUT], gctl[GCTL_HI_OUT],
                               gctl[GCTL_TMR_LSB +: 2], tctl[TCTL_MODE_LSB +: 2]);

    wdk_cfg_regs #(.DW(DW)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .locked    (locked),
        .wr_prd_lo (wr_en && sel_prd_lo),
        .wr_prd_hi (wr_en && sel_prd_hi),
        .wr_tctl   (wr_en && sel_tctl),
        .wr_gctl   (wr_en && sel_gctl),
        .wr_data   (wr_data),
        .period    (period),
        .tctl      (tctl),
        .gctl      (gctl)
    );

    wdk_counter #(.DW(DW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .tick    (tick),
        .restart (restart),
        .wr_lo   (wr_en && sel_cnt_lo && !locked),
        .wr_hi   (wr_en && sel_cnt_hi && !locked),
        .wr_data (wr_data),
        .period  (period),
        .count   (count),
        .expire  (expire)
    );

    wdk_key_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wctl_wr  (wr_en && sel_wctl),
        .key      (wr_data[WCTL_KEY_LSB +: 16]),
        .en_bit   (wr_data[WCTL_EN_BIT]),
        .flag_clr (wr_data[WCTL_FLAG_BIT]),
        .expire   (expire),
        .state    (state),
        .stat     (stat),
        .restart  (restart),
        .rst_req  (rst_req)
    );

    always_comb begin
        wctl_rd                = '0;
        wctl_rd[WCTL_FLAG_BIT] = stat.flag;
        wctl_rd[WCTL_EN_BIT]   = stat.en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            unique case (1'b1)
                sel_cnt_lo: rd_data <= count[DW-1:0];
                sel_cnt_hi: rd_data <= count[CW-1:DW];
                sel_prd_lo: rd_data <= period[DW-1:0];
                sel_prd_hi: rd_data <= period[CW-1:DW];
                sel_tctl:   rd_data <= tctl;
                sel_gctl:   rd_data <= gctl;
                sel_wctl:   rd_data <= wctl_rd;
                default:    rd_data <= '0;
            endcase
        end
    end

    assert_one_select_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_cnt_lo, sel_cnt_hi, sel_prd_lo, sel_prd_hi,
                  sel_tctl, sel_gctl, sel_wctl}));
    assert_req_needs_flag_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> stat.flag);

endmodule

// File: tb/wdk_timer_test.sv
`timescale 1ns/1ps
module wdk_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rst_req;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [3:0] A_CLO = 4, A_CHI = 5, A_PLO = 6, A_PHI = 7,
                           A_TC = 8, A_GC = 9, A_WC = 10;

    always #2.5 clk = ~clk;

    wdk_timer uut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rst_req(rst_req)
    );

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: issue a read and push the expected word
    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic chk_req(input logic e, input string t);
        @(negedge clk);
        n_checks++;
        if (rst_req !== e) begin
            n_fails++;
            $display("FAIL %s: rst_req actual %0b expected %0b", t, rst_req, e);
        end
    endtask

    task automatic service();
        wr(A_WC, 32'hA5C6_0000);
        wr(A_WC, 32'hDA7E_0000);
    endtask

    // Monitor: compare read data one cycle after the strobe
    initial begin
        forever begin
            logic pend;
            @(posedge clk);
            pend = rd_en;
            @(negedge clk);
            if (pend && exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if (rd_data !== e) begin
                    n_fails++;
                    $display("FAIL %s: rd_data actual %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 4; i <= 10; i++) rd(4'(i), 32'h0, "R1 reset word");
        chk_req(1'b0, "R1 rst_req after reset");
        // R2 unmapped addresses
        rd(4'd3, 32'h0, "R2 unmapped 3");
        rd(4'd15, 32'h0, "R2 unmapped 15");

        // R4 low half held while in reset
        wr(A_PLO, 32'd5);
        wr(A_PHI, 32'd0);
        wr(A_TC, 32'h80);
        wr(A_CLO, 32'd7);
        rd(A_CLO, 32'd0, "R4 low half held at zero");

        // R2 readback, R3 no count in mode 0
        wr(A_GC, 32'h3);
        wr(A_CLO, 32'd3);
        wr(A_CHI, 32'd1);
        rd(A_CLO, 32'd3, "R2 counter low readback");
        rd(A_CHI, 32'd1, "R2 counter high readback");
        ticks(4);
        rd(A_CLO, 32'd3, "R3 no count outside watchdog mode");

        wr(A_GC, 32'hB);
        wr(A_TC, 32'h0);
        ticks(3);
        rd(A_CLO, 32'd3, "R3 no count with enable mode off");
        rd(A_GC, 32'hB, "R2 global control readback");
        rd(A_TC, 32'h0, "R2 timer control readback");

        // R3 counting, R5 continuous wrap
        wr(A_CHI, 32'd0);
        wr(A_TC, 32'h80);
        ticks(1);
        rd(A_CLO, 32'd4, "R3 one tick one count");
        ticks(1);
        rd(A_CLO, 32'd5, "R3 count reaches period");
        ticks(1);
        rd(A_CLO, 32'd0, "R5 continuous wraps to zero");
        chk_req(1'b0, "R10 no request while unarmed");

        // R5 one-shot holds
        wr(A_TC, 32'h40);
        ticks(7);
        rd(A_CLO, 32'd5, "R5 one-shot holds at period");
        rd(A_WC, 32'h0, "R10 no flag while unarmed");
        wr(A_TC, 32'h80);
        wr(A_CLO, 32'd0);

        // R8 wrong keys in idle
        wr(A_WC, 32'h1234_4000);
        rd(A_WC, 32'h4000, "R11 enable set and readable");
        wr(A_PLO, 32'd9);
        rd(A_PLO, 32'd9, "R8 wrong key keeps unarmed");
        wr(A_WC, 32'hDA7E_0000);
        wr(A_PLO, 32'd5);
        rd(A_PLO, 32'd5, "R8 out-of-order key keeps unarmed");

        // R6 first key, R9 lock
        wr(A_WC, 32'hA5C6_0000);
        wr(A_PLO, 32'd100);
        rd(A_PLO, 32'd5, "R9 period locked");
        wr(A_TC, 32'h0);
        rd(A_TC, 32'h80, "R9 timer control locked");
        wr(A_GC, 32'h0);
        rd(A_GC, 32'hB, "R9 global control locked");
        wr(A_CLO, 32'd50);
        rd(A_CLO, 32'd0, "R9 counter locked");
        wr(A_WC, 32'h0);
        rd(A_WC, 32'h4000, "R11 enable not clearable");

        ticks(2);
        wr(A_WC, 32'h1111_0000);
        rd(A_CLO, 32'd2, "R8 wrong key no restart");
        wr(A_WC, 32'hDA7E_0000);
        rd(A_CLO, 32'd0, "R6 arming clears count");

        // R7 service, R8 out of order while armed
        ticks(3);
        wr(A_WC, 32'hDA7E_0000);
        rd(A_CLO, 32'd3, "R8 closing key alone no restart");
        service();
        rd(A_CLO, 32'd0, "R7 service clears count");
        ticks(2);
        wr(A_WC, 32'hA5C6_0000);
        wr(A_WC, 32'hBEEF_0000);
        wr(A_WC, 32'hDA7E_0000);
        rd(A_CLO, 32'd0, "R7 service survives stray key");

        // R10 keep-alive
        for (int k = 0; k < 5; k++) begin
            ticks(4);
            service();
        end
        chk_req(1'b0, "R10 serviced watchdog no request");

        // R10 timeout on exact tick
        ticks(5);
        chk_req(1'b0, "R10 no request at count equal period");
        ticks(1);
        chk_req(1'b1, "R10 request on expiry");
        rd(A_WC, 32'hC000, "R10 flag set on expiry");
        rd(A_CLO, 32'd0, "R5 wrap after expiry");

        // R11 flag clear, request sticky
        wr(A_WC, 32'h0000_8000);
        rd(A_WC, 32'h4000, "R11 flag cleared by write one");
        chk_req(1'b1, "R10 request stays high");

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule